// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches twenty-four general-purpose input pins, split into three groups, and reports any level change on them as a per-group interrupt. Each pin first passes through a two-flop synchroniser. A pin counts only if its bit is set in its group's 8-bit mask register. A rising or falling change on such a pin latches that group's pending flag. The flag latches whether or not the group is enabled, so software can poll it. It can also enable the group later and take the interrupt at once.

A group's interrupt request goes high only while three things are all true: its pending flag, its bit in the enable register, and the global interrupt-enable input. A flag is cleared in one of two ways. The interrupt controller can send a one-cycle acknowledge pulse for that group, or software can write a one to the flag bit. If a new change arrives in the same cycle as a clear, the change wins and the event is kept. Software reaches the enable, flag and mask registers over a small register bus. The bus has a 3-bit address, a single-cycle write strobe and combinational read data.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_o` is 3'b000: the enable register (address 0), the flag register (address 1) and the mask registers (addresses 2, 3 and 4, for groups 0, 1 and 2).
- R2: The enable register holds group enables in bits 2..0, where bit n enables group n. Its bits 7..3 always read zero, and writes to them are ignored.
- R3: Group 0 is pins 7..0, group 1 is pins 15..8 and group 2 is pins 23..16. A change on a masked-in pin sets only its own group's flag, which is bit n of the flag register for group n.
- R4: A rising or a falling change on a pin whose mask bit is one sets the group flag. A change on a pin whose mask bit is zero leaves the flags unchanged.
- R5: A flag is set by a masked-in change even while its group enable and the global enable are both zero. No request is raised while the enable is zero.
- R6: `irq_o[n]` is high exactly when flag n, enable bit n and `gie_i` are all one. It follows those three without a clock delay.
- R7: Writing a one to bit n of the flag register clears flag n. Writing zero to a flag bit has no effect on it.
- R8: Pin 15 is not implemented. Bit 7 of mask register 1 always reads zero and ignores writes, so pin 15 never sets a flag.
- R9: Addresses 5, 6 and 7 read 0x00, and writes to them change nothing. Bits 7..3 of the flag register read zero.
- R10: A one-cycle pulse on `ack_i[n]` clears flag n and leaves the other flags unchanged.
- R11: If a masked-in change for group n arrives in the same cycle as a clear of flag n, by acknowledge or by write-one, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 24 | Asynchronous pin levels, group n in bits 8n+7..8n |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 3 | Per-group acknowledge pulse, clears the flag |
| bus_addr_i | input | 3 | Register address: 0 enable, 1 flag, 2..4 mask 0..2 |
| bus_we_i | input | 1 | Single-cycle write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for `bus_addr_i` |
| irq_o | output | 3 | Per-group interrupt request |

## Verification
The bench goes after falling edges as well as rising ones. A detector that watched only one direction would miss half of the toggles. It sets a flag while the group is disabled and then turns the enable on. A design that gated the flag set with the enable would never raise the request. It collides an acknowledge with a fresh change in the same cycle, where a clear-priority flag would drop the event. It also writes zeros to the flag register and writes all ones to mask 1. A design that toggled flags on write, or that let pin 15 in, would show a wrong value or a spurious flag.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE,
    SEL_FLAG,
    SEL_MASK,
    SEL_NONE
  } reg_sel_e;

  // Fixed register offsets; masks occupy a contiguous run after the flags.
  localparam int unsigned OFS_ENABLE = 0;
  localparam int unsigned OFS_FLAG   = 1;
  localparam int unsigned OFS_MASK0  = 2;

  function automatic reg_sel_e decode_sel(input int unsigned addr,
                                          input int unsigned n_groups);
    if (addr == OFS_ENABLE)
      return SEL_ENABLE;
    else if (addr == OFS_FLAG)
      return SEL_FLAG;
    else if (addr >= OFS_MASK0 && addr < OFS_MASK0 + n_groups)
      return SEL_MASK;
    else
      return SEL_NONE;
  endfunction

endpackage

// File: rtl/pcirq_sync.sv
// Two-flop synchroniser plus a one-cycle history register. Reports a
// level change per pin once the pipeline holds real samples.
module pcirq_sync #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] change_o
);

  localparam int unsigned PRIME_LEN = 3;

  logic [WIDTH-1:0]     meta_q;
  logic [WIDTH-1:0]     sync_q;
  logic [WIDTH-1:0]     hist_q;
  logic [PRIME_LEN-1:0] prime_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      sync_q  <= '0;
      hist_q  <= '0;
      prime_q <= '0;
    end else begin
      meta_q  <= pins_i;
      sync_q  <= meta_q;
      hist_q  <= sync_q;
      prime_q <= {prime_q[PRIME_LEN-2:0], 1'b1};
    end
  end

  // Until the history register holds a genuine sample, report nothing.
  always_comb begin
    if (prime_q[PRIME_LEN-1])
      change_o = sync_q ^ hist_q;
    else
      change_o = '0;
  end

endmodule

// File: rtl/pcirq_regs.sv
// Register file: enable, mask registers, flag write-one-to-clear strobes
// and combinational read mux.
module pcirq_regs
  import pcirq_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned GROUP_W    = 8,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DATA_W     = 8,
  parameter logic [NUM_GROUPS*GROUP_W-1:0] IMPL_PINS = 24'hFF7FFF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          we_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_GROUPS-1:0]         flags_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NUM_GROUPS-1:0]         enable_o,
  output logic [NUM_GROUPS*GROUP_W-1:0] mask_o,
  output logic [NUM_GROUPS-1:0]         w1c_o
);

  localparam int unsigned PIN_W = NUM_GROUPS * GROUP_W;

  reg_sel_e              sel;
  logic [ADDR_W-1:0]     mask_idx;
  logic [NUM_GROUPS-1:0] enable_q;
  logic [GROUP_W-1:0]    mask_q [NUM_GROUPS];

  always_comb begin
    sel      = decode_sel(int'(addr_i), NUM_GROUPS);
    mask_idx = addr_i - ADDR_W'(OFS_MASK0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      enable_q <= '0;
    else if (we_i && sel == SEL_ENABLE)
      enable_q <= wdata_i[NUM_GROUPS-1:0];
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask
    localparam logic [GROUP_W-1:0] IMPL = IMPL_PINS[g*GROUP_W +: GROUP_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask_q[g] <= '0;
      else if (we_i && sel == SEL_MASK && mask_idx == ADDR_W'(g))
        mask_q[g] <= wdata_i[GROUP_W-1:0] & IMPL;
    end
    assign mask_o[g*GROUP_W +: GROUP_W] = mask_q[g];
  end

  always_comb begin
    if (we_i && sel == SEL_FLAG)
      w1c_o = wdata_i[NUM_GROUPS-1:0];
    else
      w1c_o = '0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_ENABLE: rdata_o = DATA_W'(enable_q);
      SEL_FLAG:   rdata_o = DATA_W'(flags_i);
      SEL_MASK: begin
        for (int g = 0; g < NUM_GROUPS; g++)
          if (mask_idx == ADDR_W'(g))
            rdata_o = DATA_W'(mask_q[g]);
      end
      SEL_NONE:   rdata_o = '0;
    endcase
  end

  assign enable_o = enable_q;

  // PIN_W kept for width documentation of mask_o.
  logic unused_ok;
  assign unused_ok = ^{PIN_W[0]};

endmodule

// File: rtl/pcirq_group.sv
// One group's pending flag and request gate.
module pcirq_group #(
  parameter int unsigned GROUP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GROUP_W-1:0] change_i,
  input  logic [GROUP_W-1:0] mask_i,
  input  logic               clear_i,
  input  logic               enable_i,
  input  logic               gie_i,
  output logic               event_o,
  output logic               flag_o,
  output logic               irq_o
);

  logic flag_q;

  assign event_o = |(change_i & mask_i);

  // A fresh event outranks any clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (event_o)
      flag_q <= 1'b1;
    else if (clear_i)
      flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & enable_i & gie_i;

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned GROUP_W    = 8,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DATA_W     = 8,
  parameter logic [NUM_GROUPS*GROUP_W-1:0] IMPL_PINS = 24'hFF7FFF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_GROUPS*GROUP_W-1:0] pins_i,
  input  logic                          gie_i,
  input  logic [NUM_GROUPS-1:0]         ack_i,
  input  logic [ADDR_W-1:0]             bus_addr_i,
  input  logic                          bus_we_i,
  input  logic [DATA_W-1:0]             bus_wdata_i,
  output logic [DATA_W-1:0]             bus_rdata_o,
  output logic [NUM_GROUPS-1:0]         irq_o
);

  localparam int unsigned PIN_W = NUM_GROUPS * GROUP_W;

  logic [PIN_W-1:0]      change;
  logic [PIN_W-1:0]      mask;
  logic [NUM_GROUPS-1:0] enable;
  logic [NUM_GROUPS-1:0] w1c;
  logic [NUM_GROUPS-1:0] flag_q;
  logic [NUM_GROUPS-1:0] grp_evt;

  pcirq_sync #(.WIDTH(PIN_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins_i   (pins_i),
    .change_o (change)
  );

  pcirq_regs #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .IMPL_PINS  (IMPL_PINS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (bus_addr_i),
    .we_i     (bus_we_i),
    .wdata_i  (bus_wdata_i),
    .flags_i  (flag_q),
    .rdata_o  (bus_rdata_o),
    .enable_o (enable),
    .mask_o   (mask),
    .w1c_o    (w1c)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    pcirq_group #(.GROUP_W(GROUP_W)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .change_i (change[g*GROUP_W +: GROUP_W]),
      .mask_i   (mask[g*GROUP_W +: GROUP_W]),
      .clear_i  (ack_i[g] | w1c[g]),
      .enable_i (enable[g]),
      .gie_i    (gie_i),
      .event_o  (grp_evt[g]),
      .flag_o   (flag_q[g]),
      .irq_o    (irq_o[g])
    );
  end

endmodule

// File: rtl/pcirq_checker.sv
module pcirq_checker #(
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DATA_W     = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  gie_i,
  input logic [NUM_GROUPS-1:0] ack_i,
  input logic [ADDR_W-1:0]     bus_addr_i,
  input logic                  bus_we_i,
  input logic [DATA_W-1:0]     bus_wdata_i,
  input logic [DATA_W-1:0]     bus_rdata_o,
  input logic [NUM_GROUPS-1:0] irq_o,
  input logic [NUM_GROUPS-1:0] flag_q,
  input logic [NUM_GROUPS-1:0] grp_evt
);

  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(2 + NUM_GROUPS);

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> gie_i); // R6

  AST_EN_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == A_EN) |-> (bus_rdata_o[DATA_W-1:NUM_GROUPS] == '0)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i >= A_END) |-> (bus_rdata_o == '0)); // R9

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> flag_q[g]); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[g] && !grp_evt[g]) |=> !flag_q[g]); // R10

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      grp_evt[g] |=> flag_q[g]); // R11

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !ack_i[g] &&
       !(bus_we_i && bus_addr_i == A_FLAG && bus_wdata_i[g])) |=> flag_q[g]); // R7
  end

endmodule

bind pin_change_irq pcirq_checker #(
  .NUM_GROUPS (NUM_GROUPS),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gie_i       (gie_i),
  .ack_i       (ack_i),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .flag_q      (flag_q),
  .grp_evt     (grp_evt)
);

// File: tb/pin_change_irq_test.sv
`timescale 1ns/1ps
module pin_change_irq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pins = '0;
  logic        gie = 1'b0;
  logic [2:0]  ack = '0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] rd;
    logic [2:0] irq;
    string      req;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  pin_change_irq uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_i      (pins),
    .gie_i       (gie),
    .ack_i       (ack),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // Monitor: pops each expected item and compares it with the outputs.
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      #0.2;
      begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (rdata !== e.rd || irq !== e.irq) begin
          failures++;
          $display("FAIL %s: rdata=%02h irq=%03b expected rdata=%02h irq=%03b",
                   e.req, rdata, irq, e.rd, e.irq);
        end
      end
    end
  end

  // Driver: called just after a falling edge.
  task automatic expect_rd(input logic [2:0] a, input logic [7:0] d,
                           input logic [2:0] i, input string req);
    exp_t e;
    addr  = a;
    e.rd  = d;
    e.irq = i;
    e.req = req;
    exp_q.push_back(e);
    #0.5;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic flip(input int p);
    @(negedge clk);
    pins[p] = ~pins[p];
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack(input int g);
    @(negedge clk);
    ack[g] = 1'b1;
    @(negedge clk);
    ack = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++)
      expect_rd(3'(a), 8'h00, 3'b000, "R1 reset value");

    // R2 reserved enable bits
    wr(3'd0, 8'hFF);
    expect_rd(3'd0, 8'h07, 3'b000, "R2 enable reserved bits");
    wr(3'd0, 8'h00);
    expect_rd(3'd0, 8'h00, 3'b000, "R2 enable cleared");

    // R9 unmapped addresses
    wr(3'd6, 8'hAA);
    for (int a = 5; a < 8; a++)
      expect_rd(3'(a), 8'h00, 3'b000, "R9 unmapped reads zero");
    for (int a = 0; a < 5; a++)
      expect_rd(3'(a), 8'h00, 3'b000, "R9 unmapped write no effect");

    // R8 pin 15 not implemented
    wr(3'd3, 8'hFF);
    expect_rd(3'd3, 8'h7F, 3'b000, "R8 mask1 bit7 reads zero");

    // R4 masked-out change ignored (pin3 rises, mask0 = 0)
    flip(3);
    expect_rd(3'd1, 8'h00, 3'b000, "R4 masked-out change");

    // R4/R5 falling change on masked-in pin, enable off
    wr(3'd2, 8'h08);
    flip(3);
    expect_rd(3'd1, 8'h01, 3'b000, "R5 flag sets with enable off");

    // R6 gating
    wr(3'd0, 8'h01);
    expect_rd(3'd1, 8'h01, 3'b000, "R6 no request without gie");
    @(negedge clk); gie = 1'b1;
    expect_rd(3'd1, 8'h01, 3'b001, "R6 request with flag enable gie");

    // R7 write-one-to-clear
    wr(3'd1, 8'h00);
    expect_rd(3'd1, 8'h01, 3'b001, "R7 write zero keeps flag");
    wr(3'd1, 8'h01);
    expect_rd(3'd1, 8'h00, 3'b000, "R7 write one clears flag");

    // R4 rising change; R10 ack per group
    flip(3);
    expect_rd(3'd1, 8'h01, 3'b001, "R4 rising change sets flag");
    pulse_ack(1);
    expect_rd(3'd1, 8'h01, 3'b001, "R10 other-group ack no effect");
    pulse_ack(0);
    expect_rd(3'd1, 8'h00, 3'b000, "R10 ack clears flag");

    // R3 group 2 on pin 23
    wr(3'd4, 8'h80);
    flip(23);
    expect_rd(3'd1, 8'h04, 3'b000, "R3 pin23 sets group2 only");
    wr(3'd0, 8'h07);
    expect_rd(3'd1, 8'h04, 3'b100, "R6 late enable raises request");

    // R8 pin 15 never sets a flag
    flip(15);
    expect_rd(3'd1, 8'h04, 3'b100, "R8 pin15 ignored");

    // R3 pin 8 sets group1
    flip(8);
    expect_rd(3'd1, 8'h06, 3'b110, "R3 pin8 sets group1");

    // R4 unmasked pin 0 ignored
    flip(0);
    expect_rd(3'd1, 8'h06, 3'b110, "R4 mask bit zero ignored");

    // R10 ack group2 keeps group1
    pulse_ack(2);
    expect_rd(3'd1, 8'h02, 3'b010, "R10 ack clears only its group");
    wr(3'd1, 8'h06);
    expect_rd(3'd1, 8'h00, 3'b000, "R7 multi-bit clear");

    // R11 change collides with ack
    @(negedge clk);
    pins[3] = ~pins[3];
    repeat (2) @(posedge clk);
    @(negedge clk);
    ack[0] = 1'b1;
    @(negedge clk);
    ack = '0;
    expect_rd(3'd1, 8'h01, 3'b001, "R11 set wins over ack");

    // R11 change collides with write-one-to-clear
    wr(3'd1, 8'h01);
    @(negedge clk);
    pins[3] = ~pins[3];
    repeat (2) @(posedge clk);
    @(negedge clk);
    addr = 3'd1; wdata = 8'h01; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    expect_rd(3'd1, 8'h01, 3'b001, "R11 set wins over write-one");

    @(negedge clk); gie = 1'b0;
    expect_rd(3'd1, 8'h01, 3'b000, "R6 gie low drops request");

    wait (exp_q.size() == 0);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule